// File: doc/BRIEF.md
# Expansion Bus I/O Slave with Wait-State Control

This block sits on the device side of an 8-bit expansion bus with a 20-bit address. It watches the address latch enable. On the falling edge of that strobe it captures the address and the DMA-owner flag. It claims an access only when the processor owns the bus (the DMA-owner flag is low) and the captured address lies in a window set by parameters. Once it has claimed the address, a low read or write command starts an access to a small internal register file.

The register file has a latency set by a parameter. While that latency runs, the block pulls the ready line low, in the same clock as the command arrives. Ready is never held low for more than 10 clocks. If the latency is longer than that, ready is released at 10 clocks anyway and a sticky timeout flag is raised.

Each stored byte carries an odd parity bit. A fault-injection input can store a corrupted parity bit, so that a later read of that byte pulls the active-low channel-check output low. Channel check stays low until a clear pulse. Read data goes out on a separate output with an output-enable, which the pad ring turns into the tri-state data driver.

Top module: `io_slave`

## Requirements
- R1: After reset, rdy is 1, chk_n is 1, data_oe is 0, timeout is 0, and every register-file byte reads as 8'h00 with valid parity.
- R2: The address and dma_en are captured at the first rising clock edge that sees addr_latch low after it was high. Later changes of bus_addr or dma_en do not alter the access in progress.
- R3: The block responds only if the captured dma_en is 0 and the captured address A satisfies BASE_ADDR <= A < BASE_ADDR + WIN_SIZE. Otherwise rdy stays 1, data_oe stays 0, and writes do not change any stored byte.
- R4: When a decoded command (rd_n or wr_n low) appears, rdy goes low in the same clock cycle. It stays low for exactly LATENCY clock cycles when 1 <= LATENCY <= 10.
- R5: rdy is never low for more than 10 consecutive cycles. With LATENCY > 10 it is released after 10 cycles, and the timeout output goes to 1 and stays there until err_clr is pulsed.
- R6: With LATENCY = 0 the block never pulls rdy low.
- R7: data_oe is 1 only while rd_n is low and the captured address is decoded. It returns to 0 in the same cycle in which rd_n rises.
- R8: A write stores data_in at offset A - BASE_ADDR, at the rising edge following the first cycle in which rdy is high during the command. A later read of the same address returns that byte on data_out while data_oe is 1.
- R9: Each byte is stored with an odd parity bit; par_flip high during a write stores the parity bit inverted. A read of a byte whose parity does not match drives chk_n low from the edge that completes the read. chk_n stays low until err_clr is pulsed, and that pulse also clears timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 20 | Bus address, bit 0 least significant |
| addr_latch | input | 1 | Address latch enable; address is taken on its falling edge |
| dma_en | input | 1 | High when the DMA controller owns the bus |
| rd_n | input | 1 | I/O read command, active low |
| wr_n | input | 1 | I/O write command, active low |
| data_in | input | 8 | Write data from the bus |
| par_flip | input | 1 | Fault injection: store inverted parity on the current write |
| err_clr | input | 1 | Clears the channel-check and timeout flags |
| data_out | output | 8 | Read data, zero when not driving |
| data_oe | output | 1 | Data driver enable |
| rdy | output | 1 | Channel ready, low inserts wait states |
| chk_n | output | 1 | Channel check, active low parity error |
| timeout | output | 1 | Sticky flag: latency exceeded the wait limit |

## Verification
Ready and the data enable follow the command pins with no register in between, so the bench checks them 1 ns after the falling edge on which it changed the command. The captured address needs one rising edge after the latch enable falls. Each ready-low period is counted one sample per cycle until release, and the count must equal the configured latency, or 10 for the long-latency copy. Stored bytes, the parity flag and the timeout flag change at the rising edge after ready is seen high. The bench reads them only after that edge, and again one cycle later to confirm they stay set.

// File: rtl/io_slave_pkg.sv
package io_slave_pkg;
  localparam int unsigned LIMIT_CYC = 10;

  // Odd parity: the stored bit makes the 9-bit word have an odd number of ones.
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic logic in_win(input logic [19:0] a, input logic [19:0] base,
                                  input int unsigned size);
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < ({1'b0, base} + 21'(size)));
  endfunction

  // Number of wait cycles actually inserted for a given access latency.
  function automatic int unsigned wait_cycles(input int unsigned lat);
    return (lat > LIMIT_CYC) ? LIMIT_CYC : lat;
  endfunction
endpackage

// File: rtl/io_addr_latch.sv
module io_addr_latch
  import io_slave_pkg::*;
#(
  parameter logic [19:0] BASE_ADDR = 20'h00300,
  parameter int unsigned WIN_SIZE  = 8,
  localparam int unsigned OFFW     = $clog2(WIN_SIZE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic            dma,
  input  logic [19:0]     addr,
  output logic            hit,
  output logic [OFFW-1:0] offset
);
  logic        ale_q, valid_q, dma_q;
  logic [19:0] addr_q;
  logic        ale_fall;

  assign ale_fall = ale_q & ~ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q   <= 1'b0;
      valid_q <= 1'b0;
      dma_q   <= 1'b1;
      addr_q  <= '0;
    end else begin
      ale_q <= ale;
      if (ale_fall) begin
        addr_q  <= addr;
        dma_q   <= dma;
        valid_q <= 1'b1;
      end
    end
  end

  assign hit    = valid_q & ~dma_q & in_win(addr_q, BASE_ADDR, WIN_SIZE);
  assign offset = OFFW'(addr_q - BASE_ADDR);
endmodule

// File: rtl/io_wait_ctrl.sv
module io_wait_ctrl
  import io_slave_pkg::*;
#(
  parameter int unsigned LATENCY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic rdy,
  output logic fire,
  output logic tmo_evt
);
  localparam int unsigned EFF  = wait_cycles(LATENCY);
  localparam bit          LONG = (LATENCY > LIMIT_CYC);
  localparam int unsigned CW   = $clog2(LIMIT_CYC + 1);

  logic acc_q;

  generate
    if (EFF == 0) begin : g_nowait
      assign rdy  = 1'b1;
      assign fire = cmd & ~acc_q;
      always_ff @(posedge clk) begin
        if (rst || !cmd) acc_q <= 1'b0;
        else if (fire)   acc_q <= 1'b1;
      end
    end else begin : g_wait
      logic [CW-1:0] cnt;
      logic          done_now;
      assign done_now = (cnt >= CW'(EFF));
      assign rdy      = ~(cmd & ~done_now);
      assign fire     = cmd & done_now & ~acc_q;
      always_ff @(posedge clk) begin
        if (rst || !cmd) begin
          cnt   <= '0;
          acc_q <= 1'b0;
        end else begin
          if (!done_now) cnt <= cnt + 1'b1;
          if (fire)      acc_q <= 1'b1;
        end
      end
    end
  endgenerate

  assign tmo_evt = fire & LONG;
endmodule

// File: rtl/io_regfile.sv
module io_regfile
  import io_slave_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          flip,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          par_ok
);
  logic [8:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= {odd_par(8'h00), 8'h00};
    end else if (we) begin
      mem[idx] <= {odd_par(wdata) ^ flip, wdata};
    end
  end

  assign rdata  = mem[idx][7:0];
  assign par_ok = ^mem[idx];
endmodule

// File: rtl/io_slave.sv
module io_slave
  import io_slave_pkg::*;
#(
  parameter logic [19:0] BASE_ADDR = 20'h00300,
  parameter int unsigned WIN_SIZE  = 8,
  parameter int unsigned LATENCY   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] bus_addr,
  input  logic        addr_latch,
  input  logic        dma_en,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [7:0]  data_in,
  input  logic        par_flip,
  input  logic        err_clr,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic        rdy,
  output logic        chk_n,
  output logic        timeout
);
  localparam int unsigned OFFW = $clog2(WIN_SIZE);

  logic            hit_w, cmd_w, fire_w, tmo_w, we_w, rd_done_w, par_ok_w;
  logic [OFFW-1:0] off_w;
  logic [7:0]      rdata_w;
  logic            chk_q, tmo_q;

  io_addr_latch #(.BASE_ADDR(BASE_ADDR), .WIN_SIZE(WIN_SIZE)) u_latch (
    .clk(clk), .rst(rst), .ale(addr_latch), .dma(dma_en), .addr(bus_addr),
    .hit(hit_w), .offset(off_w)
  );

  assign cmd_w = hit_w & (~rd_n | ~wr_n);

  io_wait_ctrl #(.LATENCY(LATENCY)) u_wait (
    .clk(clk), .rst(rst), .cmd(cmd_w), .rdy(rdy), .fire(fire_w), .tmo_evt(tmo_w)
  );

  assign we_w      = fire_w & ~wr_n;
  assign rd_done_w = fire_w & ~rd_n & wr_n;

  io_regfile #(.DEPTH(WIN_SIZE)) u_regs (
    .clk(clk), .rst(rst), .we(we_w), .flip(par_flip), .idx(off_w),
    .wdata(data_in), .rdata(rdata_w), .par_ok(par_ok_w)
  );

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      chk_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (rd_done_w && !par_ok_w) chk_q <= 1'b1;
      if (tmo_w)                  tmo_q <= 1'b1;
    end
  end

  assign data_oe  = hit_w & ~rd_n;
  assign data_out = data_oe ? rdata_w : 8'h00;
  assign chk_n    = ~chk_q;
  assign timeout  = tmo_q;
endmodule

// File: rtl/io_slave_chk.sv
module io_slave_chk (
  input logic clk,
  input logic rst,
  input logic rd_n,
  input logic rdy,
  input logic data_oe,
  input logic chk_n,
  input logic err_clr,
  input logic timeout,
  input logic cmd_w
);
  logic [4:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || rdy) low_run <= '0;
    else if (low_run != 5'd31) low_run <= low_run + 1'b1;
  end

  AST_RDY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst) !rdy |-> cmd_w); // R4
  AST_RDY_LIMIT: assert property (@(posedge clk) disable iff (rst) !rdy |-> (low_run < 5'd10)); // R5
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (rst) (timeout && !err_clr) |=> timeout); // R5
  AST_OE_READ: assert property (@(posedge clk) disable iff (rst) data_oe |-> !rd_n); // R7
  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (rst) (!chk_n && !err_clr) |=> !chk_n); // R9
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst) err_clr |=> (chk_n && !timeout)); // R9
endmodule

bind io_slave io_slave_chk u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .rdy(rdy), .data_oe(data_oe),
  .chk_n(chk_n), .err_clr(err_clr), .timeout(timeout), .cmd_w(cmd_w)
);

// File: tb/tb_io_slave.sv
`timescale 1ns/1ps
module tb_io_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic addr_latch = 1'b0, dma_en = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] data_in = '0;
  logic par_flip = 1'b0, err_clr = 1'b0;

  logic [7:0] d0, d1, d2;
  logic oe0, oe1, oe2, rdy0, rdy1, rdy2, ck0, ck1, ck2, to0, to1, to2;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  io_slave #(.LATENCY(3)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .addr_latch(addr_latch), .dma_en(dma_en),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .par_flip(par_flip), .err_clr(err_clr),
    .data_out(d0), .data_oe(oe0), .rdy(rdy0), .chk_n(ck0), .timeout(to0));
  io_slave #(.LATENCY(12)) dut_slow (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .addr_latch(addr_latch), .dma_en(dma_en),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .par_flip(par_flip), .err_clr(err_clr),
    .data_out(d1), .data_oe(oe1), .rdy(rdy1), .chk_n(ck1), .timeout(to1));
  io_slave #(.LATENCY(0)) dut_fast (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .addr_latch(addr_latch), .dma_en(dma_en),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .par_flip(par_flip), .err_clr(err_clr),
    .data_out(d2), .data_oe(oe2), .rdy(rdy2), .chk_n(ck2), .timeout(to2));

  // {address, data, expected hit}
  localparam logic [28:0] VEC [6] = '{
    {20'h00300, 8'hA5, 1'b1},
    {20'h00307, 8'h3C, 1'b1},
    {20'h00305, 8'hFF, 1'b1},
    {20'h00308, 8'h11, 1'b0},
    {20'h002FF, 8'h22, 1'b0},
    {20'h00301, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [19:0] a, input logic dma);
    @(negedge clk); addr_latch = 1'b1; bus_addr = a; dma_en = dma;
    @(negedge clk); addr_latch = 1'b0;
  endtask

  // One command phase; counts ready-low cycles per instance and records read data.
  task automatic do_cmd(input bit is_wr, input logic [7:0] wd, input logic flip,
                        input logic [19:0] addr_after,
                        output int lc0, output int lc1, output int lc2,
                        output logic [7:0] rd, output logic oe_seen, output logic oe_after);
    lc0 = 0; lc1 = 0; lc2 = 0; oe_seen = 1'b0;
    @(negedge clk);
    bus_addr = addr_after;
    if (is_wr) begin wr_n = 1'b0; data_in = wd; par_flip = flip; end
    else rd_n = 1'b0;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (!rdy0) lc0++;
      if (!rdy1) lc1++;
      if (!rdy2) lc2++;
      if (oe0) oe_seen = 1'b1;
      if (rdy0 && rdy1 && rdy2) break;
      @(negedge clk);
    end
    rd = d0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; par_flip = 1'b0;
    #1 oe_after = oe0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int l0, l1, l2;
    logic [7:0] rd;
    logic oes, oea;
    logic [19:0] a;
    logic [7:0] dv;
    logic hitx;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rdy", rdy0, 1); check("R1 chk_n", ck0, 1);
    check("R1 data_oe", oe0, 0); check("R1 timeout", to1, 0);

    latch_addr(20'h00304, 1'b0);
    do_cmd(0, 8'h00, 0, 20'h00304, l0, l1, l2, rd, oes, oea);
    check("R1 reset byte", rd, 8'h00); check("R1 parity ok", ck0, 1);

    foreach (VEC[i]) begin
      {a, dv, hitx} = VEC[i];
      latch_addr(a, 1'b0);
      do_cmd(1, dv, 0, a, l0, l1, l2, rd, oes, oea);
      check("R4 write wait", l0, hitx ? 3 : 0);
      check("R5 write wait cap", l1, hitx ? 10 : 0);
      check("R6 no wait", l2, 0);
      latch_addr(a, 1'b0);
      do_cmd(0, 8'h00, 0, a, l0, l1, l2, rd, oes, oea);
      check("R3 oe on read", oes, hitx);
      check("R8 read data", rd, hitx ? dv : 8'h00);
      check("R7 oe drops", oea, 0);
      check("R4 read wait", l0, hitx ? 3 : 0);
    end

    // R3: out-of-window writes did not alias onto offset 0
    latch_addr(20'h00300, 1'b0);
    do_cmd(0, 8'h00, 0, 20'h00300, l0, l1, l2, rd, oes, oea);
    check("R3 no alias", rd, 8'hA5);

    // R5: timeout sticky on the long-latency copy, cleared by err_clr
    check("R5 timeout set", to1, 1); check("R5 no timeout short", to0, 0);
    @(negedge clk); #1 check("R5 timeout held", to1, 1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; #1;
    check("R9 clr timeout", to1, 0);

    // R3: DMA-owned cycle is ignored
    latch_addr(20'h00303, 1'b1);
    do_cmd(1, 8'h77, 0, 20'h00303, l0, l1, l2, rd, oes, oea);
    check("R3 dma no wait", l0, 0);
    latch_addr(20'h00303, 1'b0);
    do_cmd(0, 8'h00, 0, 20'h00303, l0, l1, l2, rd, oes, oea);
    check("R3 dma write ignored", rd, 8'h00);

    // R2: address changes after the latch edge do not matter
    latch_addr(20'h00306, 1'b0);
    do_cmd(1, 8'h6E, 0, 20'h12345, l0, l1, l2, rd, oes, oea);
    latch_addr(20'h00306, 1'b0);
    @(negedge clk); bus_addr = 20'h00000; dma_en = 1'b1;
    do_cmd(0, 8'h00, 0, 20'h00000, l0, l1, l2, rd, oes, oea);
    check("R2 latched addr", rd, 8'h6E); check("R2 oe", oes, 1);
    dma_en = 1'b0;

    // R9: corrupted parity raises channel check until cleared
    latch_addr(20'h00302, 1'b0);
    do_cmd(1, 8'h5A, 1, 20'h00302, l0, l1, l2, rd, oes, oea);
    check("R9 chk idle after write", ck0, 1);
    latch_addr(20'h00302, 1'b0);
    do_cmd(0, 8'h00, 0, 20'h00302, l0, l1, l2, rd, oes, oea);
    check("R9 chk low", ck0, 0); check("R9 data kept", rd, 8'h5A);
    repeat (3) @(negedge clk); #1 check("R9 chk sticky", ck0, 0);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; #1;
    check("R9 chk cleared", ck0, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule